// File: doc/BRIEF.md
# DDR Burst-of-Two SRAM Command Scheduler

This block turns a simple request stream (read or write, an address, a two-word write payload with per-lane enables, and a valid/ready handshake) into commands for a synchronous SRAM. The SRAM has separate data-in and data-out buses, double data rate, and a fixed burst of two words. At most one command goes out per clock. A write's two data words follow its command by one cycle, together with active-low lane selects. When a write would follow a read too closely, the write is held back.

Each read is tracked by a shift register of outstanding reads. The returned word pair is sampled at a fixed number of cycles after the command and delivered with a one-cycle valid pulse. The capture point depends on a static strap. With the delay-locked loop bypassed, the device answers one cycle after the command. With it running, the device answers one and a half cycles after the command, and a read/capture PHY that realigns the half-cycle data to full cycles is assumed.

The SRAM-side data ports are full-cycle words. The external PHY serialises `sram_wd0` onto the rising input-clock edge and `sram_wd1` onto the falling one. It also delivers both returned words on `sram_q0`/`sram_q1` after `RD_PHY_STAGES` register stages.

Top module: `ddr_b2_sram_sched`

## Requirements
- R1: While `rst_n` is low: `sram_ld_n`=1, `sram_rw_n`=1, `sram_wd_en`=0, all `sram_bws*_n` bits are 1, `rsp_valid`=0 and `req_ready`=0. The first cycle after release shows no command.
- R2: A request accepted at clock edge E (`req_valid` and `req_ready` both high) appears during the cycle after E as `sram_ld_n`=0, with `sram_rw_n`=1 for a read or 0 for a write, and `sram_addr`=`req_addr`. In any cycle without an accepted request, `sram_ld_n`=1 (an idle cycle).
- R3: Read requests are never stalled: `req_ready`=1 whenever reset is released and `req_write`=0. Two writes in a row, two reads in a row, and a read that directly follows a write are each accepted on consecutive edges, with no idle cycle between them.
- R4: Between a read command and a following write command there are at least `R2W_NOPS` (1 or 2) idle cycles. A write offered directly after a read sees `req_ready`=0 for exactly `R2W_NOPS` cycles.
- R5: In the cycle after a write command, `sram_wd_en`=1, `sram_wd0`=`req_wdata[DW-1:0]` and `sram_wd1`=`req_wdata[2*DW-1:DW]` of that request. `sram_wd_en` is high in no other cycle.
- R6: During a write data cycle, `sram_bws0_n`=~`req_be[BW-1:0]` and `sram_bws1_n`=~`req_be[2*BW-1:BW]`. Select bit i guards data bits [i*DW/BW +: DW/BW] of its word. Outside write data cycles, every select bit is 1.
- R7: With `dll_bypass`=1, a read accepted at edge E has its pair sampled from `sram_q0`/`sram_q1` at edge E+2+`RD_PHY_STAGES`. `rsp_valid` is then high for the one following cycle, with `rsp_data`={`sram_q1`,`sram_q0`}.
- R8: With `dll_bypass`=0, the capture edge is one cycle later: E+3+`RD_PHY_STAGES`. `dll_bypass` is a strap that may change only while `rst_n` is low.
- R9: Each accepted read gives exactly one `rsp_valid` pulse, in request order, carrying the most recently written data for that address (only enabled lanes updated). No pulse appears without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, equal to the SRAM input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dll_bypass | input | 1 | Strap: 1 = one-cycle read latency, 0 = one-and-a-half-cycle latency |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | AW | Burst address |
| req_wdata | input | 2*DW | Write pair, word 0 in the low half |
| req_be | input | 2*BW | Active-high lane enables, word 0 in the low half |
| sram_ld_n | output | 1 | Command strobe, low = command |
| sram_rw_n | output | 1 | 1 = read, 0 = write |
| sram_addr | output | AW | Command address |
| sram_wd_en | output | 1 | Write data cycle marker |
| sram_wd0 | output | DW | Write word for the rising input-clock edge |
| sram_wd1 | output | DW | Write word for the falling input-clock edge |
| sram_bws0_n | output | BW | Active-low lane selects for word 0 |
| sram_bws1_n | output | BW | Active-low lane selects for word 1 |
| sram_q0 | input | DW | First returned read word, realigned by the PHY |
| sram_q1 | input | DW | Second returned read word, realigned by the PHY |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_data | output | 2*DW | Read pair, word 0 in the low half |

## Verification
The latency assertions assume `dll_bypass` changes only while reset is held, and that `req_valid` is low during reset. Under those conditions, the read pipeline and the outstanding-read register start empty. The capture checks also assume the PHY places the word pair on `sram_q0`/`sram_q1` exactly at the capture edge. The stimulus meets these conditions in several ways. It changes the strap only inside a reset, and drives requests only on falling edges. Its SRAM model returns each pair precisely at the edge the strap selects, so the data written in each cycle lines up with the later read responses.

// File: rtl/ddr_b2_pkg.sv
package ddr_b2_pkg;

   // Words transferred per burst on the double data rate port.
   localparam int unsigned BURST_WORDS = 2;

   // Level driven on the read/write select pin.
   typedef enum logic {
      OP_WRITE = 1'b0,
      OP_READ  = 1'b1
   } rw_op_e;

endpackage

// File: rtl/ddr_b2_turn.sv
module ddr_b2_turn #(
   parameter int R2W_NOPS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic issue_rd,
   input  logic req_write,
   output logic req_ready
);

   localparam int GW = $clog2(R2W_NOPS + 1);

   logic [GW-1:0] gap_q;

   // Counts the idle cycles still owed before a write may follow a read.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q <= '0;
      end else if (issue_rd) begin
         gap_q <= GW'(R2W_NOPS);
      end else if (gap_q != '0) begin
         gap_q <= gap_q - 1'b1;
      end
   end

   // Only a write can be held; reads and writes after writes pass at once.
   assign req_ready = rst_n && !(req_write && (gap_q != '0));

   assert_rd_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !req_write |-> req_ready);

endmodule

// File: rtl/ddr_b2_issue.sv
module ddr_b2_issue
   import ddr_b2_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 16,
   parameter int BW = 2
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 issue,
   input  logic                                 is_wr,
   input  logic [AW-1:0]                        addr,
   input  logic [BURST_WORDS*DW-1:0]            wdata,
   input  logic [BURST_WORDS*BW-1:0]            be,
   output logic                                 ld_n,
   output logic                                 rw_n,
   output logic [AW-1:0]                        addr_o,
   output logic                                 wd_en,
   output logic [BURST_WORDS-1:0][DW-1:0]       wd,
   output logic [BURST_WORDS-1:0][BW-1:0]       bws_n
);

   rw_op_e                          op_q;
   logic                            ld_q;
   logic [AW-1:0]                   addr_q;
   logic                            wbuf_vld_q;
   logic                            wd_en_q;
   logic [BURST_WORDS-1:0][DW-1:0]  wbuf_q;
   logic [BURST_WORDS-1:0][BW-1:0]  bebuf_q;

   // Command stage: one command per cycle, idle when nothing was accepted.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_q       <= 1'b0;
         op_q       <= OP_READ;
         addr_q     <= '0;
         wbuf_vld_q <= 1'b0;
         wd_en_q    <= 1'b0;
      end else begin
         ld_q       <= issue;
         wbuf_vld_q <= issue && is_wr;
         wd_en_q    <= wbuf_vld_q;
         if (issue) begin
            op_q   <= is_wr ? OP_WRITE : OP_READ;
            addr_q <= addr;
         end
      end
   end

   // Payload is parked while its command is on the pins.
   always_ff @(posedge clk) begin
      if (issue && is_wr) begin
         wbuf_q  <= wdata;
         bebuf_q <= be;
      end
   end

   // Data cycle: one register set per burst word.
   for (genvar w = 0; w < BURST_WORDS; w++) begin : g_word
      logic [DW-1:0] wd_q;
      logic [BW-1:0] bws_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wd_q  <= '0;
            bws_q <= '1;
         end else if (wbuf_vld_q) begin
            wd_q  <= wbuf_q[w];
            bws_q <= ~bebuf_q[w];
         end else begin
            bws_q <= '1;
         end
      end

      assign wd[w]    = wd_q;
      assign bws_n[w] = bws_q;
   end

   assign ld_n   = !ld_q;
   assign rw_n   = logic'(op_q);
   assign addr_o = addr_q;
   assign wd_en  = wd_en_q;

   assert_wdata_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_n && !rw_n) |=> wd_en);

   assert_wdata_only_after_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wd_en |-> $past(!ld_n && !rw_n));

   assert_selects_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wd_en |-> ((&bws_n[0]) && (&bws_n[1])));

endmodule

// File: rtl/ddr_b2_rdtrack.sv
module ddr_b2_rdtrack #(
   parameter int DW            = 16,
   parameter int RD_PHY_STAGES = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            issue_rd,
   input  logic            dll_bypass,
   input  logic [DW-1:0]   q0,
   input  logic [DW-1:0]   q1,
   output logic            rsp_valid,
   output logic [2*DW-1:0] rsp_data
);

   localparam int DEPTH   = RD_PHY_STAGES + 3;
   localparam int TAP_BYP = RD_PHY_STAGES + 1;
   localparam int TAP_DLL = RD_PHY_STAGES + 2;

   logic [DEPTH-1:0] pend_q;
   logic             capture;
   logic             valid_q;
   logic [2*DW-1:0]  data_q;

   // One bit per cycle since issue; the strap picks the tap.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else begin
         pend_q <= {pend_q[DEPTH-2:0], issue_rd};
      end
   end

   assign capture = dll_bypass ? pend_q[TAP_BYP] : pend_q[TAP_DLL];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         data_q  <= '0;
      end else begin
         valid_q <= capture;
         if (capture) begin
            data_q <= {q1, q0};
         end
      end
   end

   assign rsp_valid = valid_q;
   assign rsp_data  = data_q;

   assert_bypass_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dll_bypass |-> (rsp_valid == $past(issue_rd, RD_PHY_STAGES + 3)));

   assert_dll_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !dll_bypass |-> (rsp_valid == $past(issue_rd, RD_PHY_STAGES + 4)));

   assert_strap_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(dll_bypass));

endmodule

// File: rtl/ddr_b2_sram_sched.sv
module ddr_b2_sram_sched
   import ddr_b2_pkg::*;
#(
   parameter int AW            = 8,
   parameter int DW            = 16,
   parameter int BW            = 2,
   parameter int R2W_NOPS      = 1,
   parameter int RD_PHY_STAGES = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            dll_bypass,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic            req_write,
   input  logic [AW-1:0]   req_addr,
   input  logic [2*DW-1:0] req_wdata,
   input  logic [2*BW-1:0] req_be,
   output logic            sram_ld_n,
   output logic            sram_rw_n,
   output logic [AW-1:0]   sram_addr,
   output logic            sram_wd_en,
   output logic [DW-1:0]   sram_wd0,
   output logic [DW-1:0]   sram_wd1,
   output logic [BW-1:0]   sram_bws0_n,
   output logic [BW-1:0]   sram_bws1_n,
   input  logic [DW-1:0]   sram_q0,
   input  logic [DW-1:0]   sram_q1,
   output logic            rsp_valid,
   output logic [2*DW-1:0] rsp_data
);

   // Elaboration-time parameter checks.
   if (R2W_NOPS < 1 || R2W_NOPS > 2) begin : g_bad_r2w
      $error("R2W_NOPS must be 1 or 2");
   end
   if (RD_PHY_STAGES < 0 || RD_PHY_STAGES > 3) begin : g_bad_phy
      $error("RD_PHY_STAGES must lie in 0..3");
   end
   if (BW < 1 || (DW % BW) != 0) begin : g_bad_lanes
      $error("DW must be a multiple of BW");
   end
   if (BURST_WORDS != 2) begin : g_bad_burst
      $error("only a burst of two words is supported");
   end

   logic                            issue;
   logic                            issue_rd;
   logic [BURST_WORDS-1:0][DW-1:0]  wd_w;
   logic [BURST_WORDS-1:0][BW-1:0]  bws_w;

   assign issue    = req_valid && req_ready;
   assign issue_rd = issue && !req_write;

   ddr_b2_turn #(
      .R2W_NOPS (R2W_NOPS)
   ) u_turn (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue_rd  (issue_rd),
      .req_write (req_write),
      .req_ready (req_ready)
   );

   ddr_b2_issue #(
      .AW (AW),
      .DW (DW),
      .BW (BW)
   ) u_issue (
      .clk    (clk),
      .rst_n  (rst_n),
      .issue  (issue),
      .is_wr  (req_write),
      .addr   (req_addr),
      .wdata  (req_wdata),
      .be     (req_be),
      .ld_n   (sram_ld_n),
      .rw_n   (sram_rw_n),
      .addr_o (sram_addr),
      .wd_en  (sram_wd_en),
      .wd     (wd_w),
      .bws_n  (bws_w)
   );

   assign sram_wd0    = wd_w[0];
   assign sram_wd1    = wd_w[1];
   assign sram_bws0_n = bws_w[0];
   assign sram_bws1_n = bws_w[1];

   ddr_b2_rdtrack #(
      .DW            (DW),
      .RD_PHY_STAGES (RD_PHY_STAGES)
   ) u_rdtrack (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue_rd   (issue_rd),
      .dll_bypass (dll_bypass),
      .q0         (sram_q0),
      .q1         (sram_q1),
      .rsp_valid  (rsp_valid),
      .rsp_data   (rsp_data)
   );

   // Port-level command checks.
   logic rd_cmd;
   logic wr_cmd;
   assign rd_cmd = !sram_ld_n && sram_rw_n;
   assign wr_cmd = !sram_ld_n && !sram_rw_n;

   assert_cmd_from_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_ld_n) == $past(req_valid && req_ready));

   assert_turnaround_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmd |-> !$past(rd_cmd));

   if (R2W_NOPS > 1) begin : g_second_nop
      assert_turnaround_two_R4: assert property (@(posedge clk) disable iff (!rst_n)
         wr_cmd |-> !$past(rd_cmd, 2));
   end

endmodule

// File: tb/test_ddr_b2_sram_sched.sv
module test_ddr_b2_sram_sched;

   localparam int AW  = 8;
   localparam int DW  = 16;
   localparam int BW  = 2;
   localparam int PHY = 1;
   localparam int R2W = 2;
   localparam int LW  = DW / BW;

   typedef logic [AW-1:0]   addr_t;
   typedef logic [2*DW-1:0] word2_t;
   typedef logic [2*BW-1:0] be_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dll_bypass = 1'b1;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   addr_t         req_addr = '0;
   word2_t        req_wdata = '0;
   be_t           req_be = '0;
   logic          req_ready;
   logic          sram_ld_n, sram_rw_n, sram_wd_en, rsp_valid;
   addr_t         sram_addr;
   logic [DW-1:0] sram_wd0, sram_wd1;
   logic [BW-1:0] sram_bws0_n, sram_bws1_n;
   logic [DW-1:0] sram_q0 = '0, sram_q1 = '0;
   word2_t        rsp_data;

   ddr_b2_sram_sched #(
      .AW(AW), .DW(DW), .BW(BW), .R2W_NOPS(R2W), .RD_PHY_STAGES(PHY)
   ) i_ddr_b2_sram_sched (
      .clk(clk), .rst_n(rst_n), .dll_bypass(dll_bypass),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .sram_ld_n(sram_ld_n), .sram_rw_n(sram_rw_n), .sram_addr(sram_addr),
      .sram_wd_en(sram_wd_en), .sram_wd0(sram_wd0), .sram_wd1(sram_wd1),
      .sram_bws0_n(sram_bws0_n), .sram_bws1_n(sram_bws1_n),
      .sram_q0(sram_q0), .sram_q1(sram_q1),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data)
   );

   always #10 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct { bit wr; addr_t a; word2_t d; be_t be; int at; } cmd_t;
   typedef struct { word2_t d; int at; } rsp_t;
   typedef struct { addr_t a; int at; } mrd_t;

   cmd_t   exp_cmd[$];
   cmd_t   exp_wd[$];
   rsp_t   exp_rsp[$];
   mrd_t   mrd[$];
   word2_t shadow [0:(1<<AW)-1];
   word2_t mmem   [0:(1<<AW)-1];
   addr_t  mw_addr = '0;
   int     last_rd_cyc = -100;
   int     n_chk = 0;
   int     n_fail = 0;
   bit     done = 1'b0;

   initial begin
      for (int i = 0; i < (1 << AW); i++) begin
         shadow[i] = '0;
         mmem[i]   = '0;
      end
   end

   function automatic word2_t merge(word2_t old, word2_t nw, be_t be);
      word2_t r = old;
      for (int i = 0; i < 2 * BW; i++) begin
         if (be[i]) r[i*LW +: LW] = nw[i*LW +: LW];
      end
      return r;
   endfunction

   task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Driver: offers one request, waits for acceptance, records expectations.
   task automatic send(input bit wr, input addr_t a, input word2_t d, input be_t be,
                       output int acc, output int stalls);
      rsp_t r;
      cmd_t c;
      stalls = 0;
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      req_be    = be;
      #1;
      while (!req_ready) begin
         stalls++;
         @(negedge clk);
         #1;
      end
      acc = cyc + 1;
      c.wr = wr; c.a = a; c.d = d; c.be = be; c.at = acc;
      exp_cmd.push_back(c);
      if (wr) begin
         shadow[a] = merge(shadow[a], d, be);
      end else begin
         r.d  = shadow[a];
         r.at = acc + 2 + PHY + (dll_bypass ? 0 : 1);
         exp_rsp.push_back(r);
      end
      @(posedge clk);
      #1;
      req_valid = 1'b0;
   endtask

   // Monitor and SRAM model, both acting between clock edges.
   always @(negedge clk) begin
      cmd_t  c;
      rsp_t  r;
      mrd_t  m;
      string lreq;
      lreq = dll_bypass ? "R7" : "R8";
      if (rst_n) begin
         if (sram_wd_en) begin
            mmem[mw_addr] = merge(mmem[mw_addr], {sram_wd1, sram_wd0}, {~sram_bws1_n, ~sram_bws0_n});
            if (exp_wd.size() == 0) begin
               check(1'b0, "R5", "unexpected data cycle", 64'(1), 64'(0));
            end else begin
               c = exp_wd.pop_front();
               check(cyc == c.at, "R5", "data cycle", 64'(cyc), 64'(c.at));
               check({sram_wd1, sram_wd0} == c.d, "R5", "write words", 64'({sram_wd1, sram_wd0}), 64'(c.d));
               check({~sram_bws1_n, ~sram_bws0_n} == c.be, "R6", "lane selects",
                     64'({~sram_bws1_n, ~sram_bws0_n}), 64'(c.be));
            end
         end else begin
            check((&sram_bws0_n) && (&sram_bws1_n), "R6", "idle selects",
                  64'({sram_bws1_n, sram_bws0_n}), 64'({2*BW{1'b1}}));
         end
         if (!sram_ld_n) begin
            if (exp_cmd.size() == 0) begin
               check(1'b0, "R2", "unexpected command", 64'(1), 64'(0));
            end else begin
               c = exp_cmd.pop_front();
               check(cyc == c.at, "R2", "command cycle", 64'(cyc), 64'(c.at));
               check(sram_rw_n == !c.wr, "R2", "rw level", 64'(sram_rw_n), 64'(!c.wr));
               check(sram_addr == c.a, "R2", "address", 64'(sram_addr), 64'(c.a));
               if (c.wr) begin
                  check(cyc - last_rd_cyc > R2W, "R4", "idle cycles after read",
                        64'(cyc - last_rd_cyc - 1), 64'(R2W));
                  c.at = cyc + 1;
                  exp_wd.push_back(c);
                  mw_addr = sram_addr;
               end else begin
                  last_rd_cyc = cyc;
                  m.a  = sram_addr;
                  m.at = cyc + 1 + PHY + (dll_bypass ? 0 : 1);
                  mrd.push_back(m);
               end
            end
         end
         if (rsp_valid) begin
            if (exp_rsp.size() == 0) begin
               check(1'b0, "R9", "response without read", 64'(1), 64'(0));
            end else begin
               r = exp_rsp.pop_front();
               check(cyc == r.at, lreq, "response cycle", 64'(cyc), 64'(r.at));
               check(rsp_data == r.d, "R9", "response data", 64'(rsp_data), 64'(r.d));
            end
         end
      end
      if (mrd.size() > 0 && mrd[0].at == cyc) begin
         m = mrd.pop_front();
         {sram_q1, sram_q0} = mmem[m.a];
      end else begin
         {sram_q1, sram_q0} = word2_t'(32'hDEAD_0BAD);
      end
   end

   task automatic do_reset(input bit byp);
      rst_n = 1'b0;
      dll_bypass = byp;
      repeat (3) @(negedge clk);
      check(sram_ld_n && sram_rw_n && !sram_wd_en && !rsp_valid && !req_ready, "R1",
            "outputs in reset", 64'({sram_ld_n, sram_rw_n, sram_wd_en, rsp_valid, req_ready}),
            64'(5'b11000));
      check((&sram_bws0_n) && (&sram_bws1_n), "R1", "selects in reset",
            64'({sram_bws1_n, sram_bws0_n}), 64'({2*BW{1'b1}}));
      exp_cmd.delete();
      exp_wd.delete();
      exp_rsp.delete();
      mrd.delete();
      rst_n = 1'b1;
      @(negedge clk);
      check(sram_ld_n && req_ready, "R1", "first cycle after reset",
            64'({sram_ld_n, req_ready}), 64'(2'b11));
   endtask

   task automatic run_traffic(input int base);
      int a1, a2, s;
      send(1'b1, addr_t'(base), word2_t'(32'h1111_2222), be_t'(4'hF), a1, s);
      send(1'b1, addr_t'(base + 1), word2_t'(32'hAAAA_BBBB), be_t'(4'b0101), a2, s);
      check(a2 == a1 + 1, "R3", "write after write consecutive", 64'(a2 - a1), 64'(1));
      send(1'b0, addr_t'(base), '0, '0, a1, s);
      send(1'b0, addr_t'(base + 1), '0, '0, a2, s);
      check(a2 == a1 + 1, "R3", "read after read consecutive", 64'(a2 - a1), 64'(1));
      check(s == 0, "R3", "read stalls", 64'(s), 64'(0));
      send(1'b0, addr_t'(base + 2), '0, '0, a1, s);
      send(1'b1, addr_t'(base + 2), word2_t'(32'h5A5A_C3C3), be_t'(4'hF), a2, s);
      check(a2 - a1 == R2W + 1, "R4", "write after read spacing", 64'(a2 - a1), 64'(R2W + 1));
      check(s == R2W, "R4", "ready low cycles", 64'(s), 64'(R2W));
      send(1'b1, addr_t'(base + 3), word2_t'(32'h0F0F_7777), be_t'(4'hF), a1, s);
      send(1'b0, addr_t'(base + 3), '0, '0, a2, s);
      check(a2 == a1 + 1, "R3", "read after write no idle", 64'(a2 - a1), 64'(1));
      send(1'b1, addr_t'(base + 2), word2_t'(32'hFFFF_FFFF), be_t'(4'b1000), a1, s);
      send(1'b1, addr_t'(base + 2), word2_t'(32'h0000_0000), be_t'(4'b0001), a1, s);
      send(1'b0, addr_t'(base + 2), '0, '0, a2, s);
      for (int i = 0; i < 12; i++) begin
         send(i % 3 == 1, addr_t'(base + ((i * 5) % 8)), word2_t'(32'h1357_9BDF * (i + 1)),
              be_t'(i + 1), a1, s);
      end
      repeat (PHY + 8) @(negedge clk);
      check(exp_rsp.size() == 0 && exp_cmd.size() == 0 && exp_wd.size() == 0, "R9",
            "all expected items seen", 64'(exp_rsp.size() + exp_cmd.size() + exp_wd.size()), 64'(0));
   endtask

   initial begin
      do_reset(1'b1);
      run_traffic(0);
      do_reset(1'b0);
      run_traffic(32);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

endmodule